// File: doc/BRIEF.md
# Prescaled Multi-Channel Timer Unit

This block is a memory-mapped timer peripheral. One shared prescaler divides the clock into a tick. Between one and eight identical channels count down by one on each tick. A channel expires on the tick that finds its counter at zero, so a loaded value N lasts N+1 ticks. On expiry the channel can raise a one-cycle interrupt pulse on its own line and set a sticky pending flag. It then either reloads and keeps counting, or stops and clears its own enable.

Software reaches the block through a simple 32-bit register port with a write strobe and a combinational read path. The unit page holds the prescaler current value, the prescaler reload and a read-only capability word. Each channel has a 16-byte page with a counter, a reload value and a control word.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the prescaler value, the prescaler reload and every channel's counter, reload and control word read as 0, and every interrupt output is low.
- R2: Byte offset 0x10*(n+1) starts channel n's page. Within a page, +0x0 is the counter, +0x4 the reload and +0x8 the control word. Offset +0xC, unit offset 0x0C, and any page for a channel at or above NUM_CH read as 0, and writes to them change nothing.
- R3: The prescaler value (0x00) and prescaler reload (0x04) keep only the low 16 bits of a write.
- R4: The prescaler ticks in each cycle where its value is 0, and it then reloads. Otherwise it decrements. A reload of R therefore gives one tick every R+1 cycles.
- R5: An enabled channel loaded with N expires on the (N+1)th tick. If interrupt enable (control bit 3) is set, its interrupt output is high for exactly the cycle after that tick, and the pending flag (control bit 4) is set.
- R6: With interrupt enable clear, an expiry drives no pulse and leaves pending clear.
- R7: With auto-restart (control bit 1) set, expiry copies the reload into the counter and counting continues.
- R8: With auto-restart clear, expiry leaves the counter at 0 and clears enable (control bit 0).
- R9: A control write with bit 4 set clears pending. A control write with bit 4 clear leaves pending unchanged.
- R10: A control write with load (bit 2) set copies the reload into the counter at once. The load bit and bits 5 and 6 always read as 0.
- R11: When enable is clear, the counter holds its value. A counter write sets the counter directly.
- R12: Offset 0x08 reads as the capability word: bits 2:0 = NUM_CH mod 8, bits 7:3 = IRQ_BASE, bit 8 = 1, bit 9 = 1, and all other bits 0. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CH | One interrupt pulse line per channel |

## Verification
A wrong counter, prescaler or control state shows at the ports in one of two ways. The interrupt pulse lands in the wrong cycle of a watched window, or a register readback differs right after the access that should have set it. The bench therefore records each interrupt line cycle by cycle after an enabling write, and compares the whole pulse pattern with the count of N+1 ticks times the prescaler period. An error in the sticky pending flag or the one-shot enable clear becomes visible at the first control readback after the expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;

  // control word bit positions (decoded by software)
  localparam int CB_EN = 0;
  localparam int CB_RS = 1;
  localparam int CB_LD = 2;
  localparam int CB_IE = 3;
  localparam int CB_IP = 4;

  typedef enum logic [1:0] {
    SLOT_CNT  = 2'd0,
    SLOT_RLD  = 2'd1,
    SLOT_CTL  = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  typedef struct packed {
    logic ip;
    logic ie;
    logic rs;
    logic en;
  } ctl_t;

  function automatic logic [DATA_W-1:0] ctl_word(input ctl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CB_EN] = c.en;
    w[CB_RS] = c.rs;
    w[CB_IE] = c.ie;
    w[CB_IP] = c.ip;
    return w;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_val,
  input  logic             wr_rld,
  input  logic [PRE_W-1:0] wdata,
  output logic [PRE_W-1:0] val,
  output logic [PRE_W-1:0] rld,
  output logic             tick
);
  logic [PRE_W-1:0] val_q, val_d, rld_q, rld_d;

  always_comb begin
    val_d = val_q;
    rld_d = rld_q;
    tick  = 1'b0;
    if (wr_rld) rld_d = wdata;
    if (wr_val) begin
      val_d = wdata;
    end else if (val_q == '0) begin
      tick  = 1'b1;
      val_d = rld_q;
    end else begin
      val_d = val_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      rld_q <= '0;
    end else begin
      val_q <= val_d;
      rld_q <= rld_d;
    end
  end

  assign val = val_q;
  assign rld = rld_q;

  // R4: after a tick the value restarts from the reload
  a_r4_tick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_val && !wr_rld) |=> (val_q == $past(rld_q)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_cnt,
  input  logic              wr_rld,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  rld,
  output logic [DATA_W-1:0] ctl,
  output logic              irq
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  ctl_t             ctl_q, ctl_d;
  logic             irq_q, irq_d;
  logic             expire;
  logic             any_wr;
  logic             unused_wbits;

  assign any_wr       = wr_cnt | wr_rld | wr_ctl;
  assign unused_wbits = ^wdata;

  // a bus write to this page wins over the tick in that cycle
  always_comb begin
    cnt_d  = cnt_q;
    rld_d  = rld_q;
    ctl_d  = ctl_q;
    irq_d  = 1'b0;
    expire = 1'b0;
    if (wr_ctl) begin
      ctl_d.en = wdata[CB_EN];
      ctl_d.rs = wdata[CB_RS];
      ctl_d.ie = wdata[CB_IE];
      ctl_d.ip = wdata[CB_IP] ? 1'b0 : ctl_q.ip;
      if (wdata[CB_LD]) cnt_d = rld_q;
    end else if (wr_cnt) begin
      cnt_d = wdata[CNT_W-1:0];
    end else if (wr_rld) begin
      rld_d = wdata[CNT_W-1:0];
    end else if (tick && ctl_q.en) begin
      if (cnt_q == '0) begin
        expire = 1'b1;
        if (ctl_q.ie) begin
          ctl_d.ip = 1'b1;
          irq_d    = 1'b1;
        end
        if (ctl_q.rs) cnt_d = rld_q;
        else          ctl_d.en = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      ctl_q <= ctl_d;
      irq_q <= irq_d;
    end
  end

  assign cnt = cnt_q;
  assign rld = rld_q;
  assign ctl = ctl_word(ctl_q);
  assign irq = irq_q;

  // R5: a pulse always comes with the pending flag
  a_r5_irq_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ctl_q.ip);
  // R6: no pulse unless interrupt enable was set before it
  a_r6_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ctl_q.ie));
  // R8: a one-shot expiry drops enable
  a_r8_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctl_q.rs) |=> !ctl_q.en);
  // R11: a disabled channel holds its counter
  a_r11_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !any_wr) |=> $stable(cnt_q));
  // R10: the load bit copies the reload value
  a_r10_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata[CB_LD]) |=> (cnt_q == $past(rld_q)));
  // R9: writing zero into the pending bit keeps it
  a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !wdata[CB_IP] && ctl_q.ip) |=> ctl_q.ip);
endmodule

// File: rtl/tmr_regbus.sv
module tmr_regbus
  import tmr_pkg::*;
#(
  parameter int              NUM_CH   = 2,
  parameter int              CNT_W    = 32,
  parameter int              PRE_W    = 16,
  parameter logic [DATA_W-1:0] CFG_WORD = '0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [7:0]                     addr,
  input  logic                           we,
  input  logic [PRE_W-1:0]               pre_val,
  input  logic [PRE_W-1:0]               pre_rld,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   ch_rld,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_ctl,
  output logic                           pre_wr_val,
  output logic                           pre_wr_rld,
  output logic [NUM_CH-1:0]              ch_wr_cnt,
  output logic [NUM_CH-1:0]              ch_wr_rld,
  output logic [NUM_CH-1:0]              ch_wr_ctl,
  output logic [DATA_W-1:0]              rdata
);
  logic [3:0] page;
  slot_e      slot;
  logic       unused_lsb;

  assign page       = addr[7:4];
  assign slot       = slot_e'(addr[3:2]);
  assign unused_lsb = ^addr[1:0];

  // unit page: the capability slot ignores writes
  assign pre_wr_val = we && (page == 4'd0) && (slot == SLOT_CNT);
  assign pre_wr_rld = we && (page == 4'd0) && (slot == SLOT_RLD);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic hit;
    assign hit          = we && (page == 4'(i + 1));
    assign ch_wr_cnt[i] = hit && (slot == SLOT_CNT);
    assign ch_wr_rld[i] = hit && (slot == SLOT_RLD);
    assign ch_wr_ctl[i] = hit && (slot == SLOT_CTL);
  end

  always_comb begin
    rdata = '0;
    if (page == 4'd0) begin
      case (slot)
        SLOT_CNT: rdata = DATA_W'(pre_val);
        SLOT_RLD: rdata = DATA_W'(pre_rld);
        SLOT_CTL: rdata = CFG_WORD;
        default:  rdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (page == 4'(i + 1)) begin
          case (slot)
            SLOT_CNT: rdata = DATA_W'(ch_cnt[i]);
            SLOT_RLD: rdata = DATA_W'(ch_rld[i]);
            SLOT_CTL: rdata = ch_ctl[i];
            default:  rdata = '0;
          endcase
        end
      end
    end
  end

  // R2: a single write reaches at most one register
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pre_wr_val, pre_wr_rld, ch_wr_cnt, ch_wr_rld, ch_wr_ctl}));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int IRQ_BASE = 8,
  parameter int CNT_W    = 32,
  parameter int PRE_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam logic [DATA_W-1:0] CFG_WORD =
    {22'd0, 1'b1, 1'b1, 5'(IRQ_BASE), 3'(NUM_CH)};

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [PRE_W-1:0]              pre_val, pre_rld;
  logic                          tick, pre_wr_val, pre_wr_rld;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt, ch_rld;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_ctl;
  logic [NUM_CH-1:0]             ch_wr_cnt, ch_wr_rld, ch_wr_ctl;

  tmr_regbus #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W), .CFG_WORD(CFG_WORD)
  ) u_bus (
    .clk(clk), .rst_n(rst_ni), .addr(bus_addr), .we(bus_we),
    .pre_val(pre_val), .pre_rld(pre_rld),
    .ch_cnt(ch_cnt), .ch_rld(ch_rld), .ch_ctl(ch_ctl),
    .pre_wr_val(pre_wr_val), .pre_wr_rld(pre_wr_rld),
    .ch_wr_cnt(ch_wr_cnt), .ch_wr_rld(ch_wr_rld), .ch_wr_ctl(ch_wr_ctl),
    .rdata(bus_rdata)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_ni), .wr_val(pre_wr_val), .wr_rld(pre_wr_rld),
    .wdata(bus_wdata[PRE_W-1:0]), .val(pre_val), .rld(pre_rld), .tick(tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_ni), .tick(tick),
      .wr_cnt(ch_wr_cnt[i]), .wr_rld(ch_wr_rld[i]), .wr_ctl(ch_wr_ctl[i]),
      .wdata(bus_wdata),
      .cnt(ch_cnt[i]), .rld(ch_rld[i]), .ctl(ch_ctl[i]), .irq(irq[i])
    );
  end

  // R1: interrupts stay low while the block is held in reset
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_ni |-> (irq == '0));
endmodule

// File: tb/tmr_unit_tb_top.sv
module tmr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tmr_unit #(.NUM_CH(2), .IRQ_BASE(8), .CNT_W(32), .PRE_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {we, addr, wdata, expected read, requirement number}
  localparam int NV = 26;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0,        32'h0,        8'd1},  // R1
    {1'b0, 8'h04, 32'h0,        32'h0,        8'd1},  // R1
    {1'b0, 8'h10, 32'h0,        32'h0,        8'd1},  // R1
    {1'b0, 8'h14, 32'h0,        32'h0,        8'd1},  // R1
    {1'b0, 8'h18, 32'h0,        32'h0,        8'd1},  // R1
    {1'b0, 8'h20, 32'h0,        32'h0,        8'd1},  // R1
    {1'b0, 8'h28, 32'h0,        32'h0,        8'd1},  // R1
    {1'b0, 8'h08, 32'h0,        32'h342,      8'd12}, // R12
    {1'b1, 8'h08, 32'hFFFFFFFF, 32'h0,        8'd12},
    {1'b0, 8'h08, 32'h0,        32'h342,      8'd12}, // R12
    {1'b1, 8'h04, 32'hABCD1234, 32'h0,        8'd3},
    {1'b0, 8'h04, 32'h0,        32'h1234,     8'd3},  // R3
    {1'b1, 8'h04, 32'h0,        32'h0,        8'd3},
    {1'b0, 8'h04, 32'h0,        32'h0,        8'd3},  // R3
    {1'b1, 8'h00, 32'hFFFF0005, 32'h0,        8'd3},
    {1'b0, 8'h00, 32'h0,        32'h5,        8'd3},  // R3
    {1'b1, 8'h34, 32'h55,       32'h0,        8'd2},
    {1'b0, 8'h34, 32'h0,        32'h0,        8'd2},  // R2
    {1'b0, 8'h0C, 32'h0,        32'h0,        8'd2},  // R2
    {1'b0, 8'h1C, 32'h0,        32'h0,        8'd2},  // R2
    {1'b1, 8'h14, 32'h1234ABCD, 32'h0,        8'd2},
    {1'b1, 8'h24, 32'h77,       32'h0,        8'd2},
    {1'b0, 8'h14, 32'h0,        32'h1234ABCD, 8'd2},  // R2
    {1'b0, 8'h24, 32'h0,        32'h77,       8'd2},  // R2
    {1'b1, 8'h18, 32'h60,       32'h0,        8'd10},
    {1'b0, 8'h18, 32'h0,        32'h0,        8'd10}  // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    bus_we   = 1'b0;
    #1 v = bus_rdata;
  endtask

  // index 0 is the negedge right after the last enabling write
  task automatic watch(input int ch, input int n, output logic [31:0] mask);
    mask = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mask[i] = irq[ch];
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, m;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    do_reset();
    @(negedge clk);
    chk("R1 irq after reset", 32'(irq), 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][80]) begin
        wr(VEC[k][79:72], VEC[k][71:40]);
      end else begin
        rd(VEC[k][79:72], v);
        chk($sformatf("R%0d vector %0d", VEC[k][7:0], k), v, VEC[k][39:8]);
      end
    end

    // R10 / R11: load with enable clear, then holding
    wr(8'h14, 32'd7);
    wr(8'h18, 32'h4);
    rd(8'h10, v); chk("R10 load copies reload", v, 32'd7);
    rd(8'h18, v); chk("R10 load reads zero", v, 32'h0);
    repeat (5) @(posedge clk);
    rd(8'h10, v); chk("R11 counter holds when disabled", v, 32'd7);
    wr(8'h10, 32'd9);
    rd(8'h10, v); chk("R11 counter write", v, 32'd9);

    // R5 / R8: one-shot on channel 1, N=3, prescaler reload 0
    wr(8'h20, 32'd3);
    wr(8'h28, 32'h9);
    watch(1, 10, m); chk("R5 pulse after N+1 ticks, one cycle", m, 32'h10);
    rd(8'h28, v); chk("R8 enable cleared, R5 pending set", v, 32'h18);
    rd(8'h20, v); chk("R8 counter stays at zero", v, 32'h0);

    // R6: no interrupt enable; control write with bit4 also clears pending
    wr(8'h20, 32'd2);
    wr(8'h28, 32'h11);
    watch(1, 8, m); chk("R6 no pulse without interrupt enable", m, 32'h0);
    rd(8'h28, v); chk("R6 pending stays clear, enable dropped", v, 32'h0);

    // R9: sticky pending, write-one-to-clear
    wr(8'h10, 32'd0);
    wr(8'h18, 32'h9);
    watch(0, 4, m); chk("R5 expiry on first tick for N=0", m, 32'h2);
    rd(8'h18, v); chk("R9 pending set", v, 32'h18);
    wr(8'h18, 32'h8);
    rd(8'h18, v); chk("R9 zero in bit4 keeps pending", v, 32'h18);
    wr(8'h18, 32'h10);
    rd(8'h18, v); chk("R9 one in bit4 clears pending", v, 32'h0);

    // R7: auto restart, reload 2 -> expiry every 3 ticks
    wr(8'h14, 32'd2);
    wr(8'h10, 32'd0);
    wr(8'h18, 32'hB);
    watch(0, 11, m); chk("R7 periodic pulses", m, 32'h492);
    wr(8'h18, 32'h10);
    rd(8'h18, v); chk("R7 channel stopped", v, 32'h0);

    // R4: prescaler reload 3 -> tick every 4 cycles
    wr(8'h04, 32'd3);
    wr(8'h00, 32'd3);
    wr(8'h20, 32'd1);
    wr(8'h28, 32'h9);
    watch(1, 10, m); chk("R4 prescaled expiry", m, 32'h40);
    wr(8'h04, 32'd0);

    // R1: reset in mid activity
    wr(8'h14, 32'd4);
    wr(8'h10, 32'd5);
    wr(8'h18, 32'hB);
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 irq low in reset", 32'(irq), 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd(8'h10, v); chk("R1 counter cleared", v, 32'h0);
    rd(8'h14, v); chk("R1 reload cleared", v, 32'h0);
    rd(8'h18, v); chk("R1 control cleared", v, 32'h0);
    rd(8'h04, v); chk("R1 prescaler reload cleared", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule